// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block sits behind a host's I/O port space. It implements the two-step mechanism used to reach the configuration registers of slot/function targets. The host first writes a 32-bit value to an address port. That value selects a bus, a slot, a function and a register offset. The host then reads or writes through a four-byte data window. Each byte of the window adds its own lane offset to the latched register offset. The access width can be one, two or four bytes.

The decoder checks each data-window access. It drops the access if the size is illegal, if the effective offset is misaligned for that size, or if the addressed function is absent. Otherwise it issues a single request to a generic byte-addressed register array. The request carries a dword index, byte enables and lane-aligned write data. Read data returned by the target is moved down to bit 0 and truncated to the access size. When a read covers the header-type byte, its multi-function flag is rewritten from live slot occupancy. Two interrupt-routing ports are claimed, and writes to them do nothing.

A read is answered two clock edges after it is presented. A configuration request is visible on the target interface in the cycle after the host access.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the address latch holds zero, `io_rvalid` is low and `cfg_req` is low.
- R2: A 4-byte write to port 0x0CF8 loads the address latch. The fields are: offset in bits 7:0, function in bits 10:8, slot in bits 15:11, bus in bits 23:16. Bits 31:24 are stored as zero. A 4-byte read of 0x0CF8 returns the latch. A 1- or 2-byte write to 0x0CF8 leaves the latch unchanged. A 1- or 2-byte read of 0x0CF8 returns all ones truncated to the size.
- R3: Ports 0x0CFC to 0x0CFF form the data window. The effective offset is the latched offset plus (port - 0x0CFC), modulo 256. A forwarded access drives `cfg_dword` = effective offset bits 7:2. It drives `cfg_be` with one bit per byte covered, starting at lane = effective offset bits 1:0. Write data moves from bit 0 up to that lane. Each access produces at most one request, raised in the cycle after the access.
- R4: `io_size` gives the access size as a byte count. Only 1, 2 and 4 are legal. Any other size on the data window produces no request, and a read returns 32'hFFFFFFFF.
- R5: An access whose effective offset is not a multiple of its size produces no request. Such a read returns all ones truncated to the size.
- R6: An access to a slot/function whose bit in `present` (index slot*NFUNC+func) is clear produces no request. Such a read returns all ones truncated to the size.
- R7: Forwarded read data is the target dword shifted down by lane*8 bits, masked to the access size and zero-extended to 32 bits.
- R8: A read covering offset 0x0E (dword 3, byte lane 2) has its bit 7 (bit 23 of the dword) forced. It is forced to 1 when more than one function of that slot is present, and to 0 otherwise. Occupancy is sampled when the response is formed.
- R9: Ports 0x0C00 and 0x0C01 are claimed (`io_hit` high). Writes to them cause no request and leave the latch unchanged. Reads of them return all ones. Unclaimed ports keep `io_hit` low, and reads of them also return all ones.
- R10: Every read is answered with `io_rvalid` high for one cycle, two clock edges after the access edge. Writes produce no `io_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | Host I/O access strobe, one access per cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_port | input | 16 | I/O port number |
| io_size | input | 3 | Access size in bytes |
| io_wdata | input | 32 | Write data, right-aligned |
| io_hit | output | 1 | Port belongs to this block |
| io_rvalid | output | 1 | Read response valid |
| io_rdata | output | 32 | Read response, right-aligned |
| present | input | NSLOT*NFUNC | Function occupancy, bit slot*NFUNC+func |
| cfg_req | output | 1 | Register array request |
| cfg_we | output | 1 | Request is a write |
| cfg_slot | output | 5 | Target slot |
| cfg_func | output | 3 | Target function |
| cfg_dword | output | 6 | Dword index within the function |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rdata | input | 32 | Dword returned by the target during the request |

## Verification
The hardest case is the header-type patch. It depends on three things at once: the latched offset, the data-port lane and the occupancy of every function in the slot. Each flip of the flag needs its own combination.

The stimulus therefore uses a target model whose header byte already carries the opposite of the expected flag. It reaches offset 0x0E both with a dword read and with a single-byte read through the third lane. It then changes `present` between two identical reads, so that the patch is seen to follow live occupancy. Misalignment is reached through lane arithmetic, by combining an odd latched offset with an odd data port. This checks both the rejected and the accepted outcome.

// File: rtl/cfgpd_pkg.sv
package cfgpd_pkg;

    localparam logic [15:0] PORT_ADDR = 16'h0CF8;
    localparam logic [15:0] PORT_DATA = 16'h0CFC;
    localparam logic [15:0] PORT_IRQ0 = 16'h0C00;
    localparam logic [15:0] PORT_IRQ1 = 16'h0C01;

    localparam int OFF_W    = 8;
    localparam int FUNC_W   = 3;
    localparam int SLOT_W   = 5;
    localparam int DW_W     = OFF_W - 2;
    localparam int FUNC_LSB = 8;
    localparam int SLOT_LSB = 11;

    localparam logic [31:0] LATCH_MASK = 32'h00FF_FFFF;

    localparam logic [DW_W-1:0] HDR_DW   = 6'd3;
    localparam int              HDR_LANE = 2;
    localparam int              MF_BIT   = 23;

    typedef enum logic [1:0] {
        PK_NONE,
        PK_ADDR,
        PK_DATA,
        PK_IRQ
    } port_kind_e;

    typedef enum logic [1:0] {
        AK_IDLE,
        AK_CFG,
        AK_LATCH,
        AK_ONES
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e         kind;
        logic              we;
        logic [SLOT_W-1:0] slot;
        logic [FUNC_W-1:0] func;
        logic [DW_W-1:0]   dw;
        logic [3:0]        be;
        logic [1:0]        lane;
        logic [2:0]        size;
        logic [31:0]       data;
    } stage_t;

    function automatic logic size_legal(input logic [2:0] s);
        return (s == 3'd1) || (s == 3'd2) || (s == 3'd4);
    endfunction

    function automatic logic is_aligned(input logic [1:0] lo, input logic [2:0] s);
        case (s)
            3'd1:    return 1'b1;
            3'd2:    return ~lo[0];
            3'd4:    return (lo == 2'd0);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [3:0] lane_be(input logic [1:0] lo, input logic [2:0] s);
        case (s)
            3'd1:    return 4'b0001 << lo;
            3'd2:    return 4'b0011 << lo;
            3'd4:    return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] size_mask(input logic [2:0] s);
        case (s)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch
    import cfgpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       latch_q,
    output logic [OFF_W-1:0]  off,
    output logic [FUNC_W-1:0] func,
    output logic [SLOT_W-1:0] slot
);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else if (wr_en) begin
            latch_q <= wr_data & LATCH_MASK;
        end
    end

    assign off  = latch_q[OFF_W-1:0];
    assign func = latch_q[FUNC_LSB +: FUNC_W];
    assign slot = latch_q[SLOT_LSB +: SLOT_W];

    // R2: a full-width write to the address port is visible in the next cycle
    assert_latch_capture_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (latch_q == ($past(wr_data) & LATCH_MASK)));

    // R1: reset leaves the latch cleared
    assert_latch_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (latch_q == 32'd0));

endmodule

// File: rtl/cfg_access_decode.sv
module cfg_access_decode
    import cfgpd_pkg::*;
#(
    parameter int NSLOT = 32,
    parameter int NFUNC = 8
) (
    input  logic                   io_valid,
    input  logic                   io_write,
    input  logic [15:0]            io_port,
    input  logic [2:0]             io_size,
    input  logic [31:0]            io_wdata,
    input  logic [31:0]            latch_q,
    input  logic [OFF_W-1:0]       lat_off,
    input  logic [FUNC_W-1:0]      lat_func,
    input  logic [SLOT_W-1:0]      lat_slot,
    input  logic [NSLOT*NFUNC-1:0] present,
    output logic                   io_hit,
    output logic                   latch_wr,
    output stage_t                 nxt
);

    port_kind_e       pk;
    logic [OFF_W-1:0] eff;
    logic             fn_present;
    logic             fwd_ok;

    always_comb begin
        if (io_port == PORT_ADDR) begin
            pk = PK_ADDR;
        end else if (io_port[15:2] == PORT_DATA[15:2]) begin
            pk = PK_DATA;
        end else if (io_port == PORT_IRQ0 || io_port == PORT_IRQ1) begin
            pk = PK_IRQ;
        end else begin
            pk = PK_NONE;
        end
    end

    assign eff = lat_off + {{(OFF_W-2){1'b0}}, io_port[1:0]};

    always_comb begin
        int idx;
        fn_present = 1'b0;
        idx = int'(lat_slot) * NFUNC + int'(lat_func);
        if (int'(lat_slot) < NSLOT && int'(lat_func) < NFUNC) begin
            fn_present = present[idx];
        end
    end

    assign fwd_ok   = size_legal(io_size) && is_aligned(eff[1:0], io_size) && fn_present;
    assign io_hit   = io_valid && (pk != PK_NONE);
    assign latch_wr = io_valid && io_write && (pk == PK_ADDR) && (io_size == 3'd4);

    always_comb begin
        nxt      = '0;
        nxt.kind = AK_IDLE;
        if (io_valid) begin
            nxt.we   = io_write;
            nxt.slot = lat_slot;
            nxt.func = lat_func;
            nxt.dw   = eff[OFF_W-1:2];
            nxt.lane = eff[1:0];
            nxt.size = io_size;
            nxt.be   = lane_be(eff[1:0], io_size);
            nxt.data = io_wdata << {eff[1:0], 3'b000};
            case (pk)
                PK_DATA: begin
                    if (fwd_ok) begin
                        nxt.kind = AK_CFG;
                    end else if (!io_write) begin
                        nxt.kind = AK_ONES;
                    end
                end
                PK_ADDR: begin
                    if (!io_write) begin
                        if (io_size == 3'd4) begin
                            nxt.kind = AK_LATCH;
                            nxt.data = latch_q;
                        end else begin
                            nxt.kind = AK_ONES;
                        end
                    end
                end
                default: begin
                    if (!io_write) begin
                        nxt.kind = AK_ONES;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/cfg_mf_detect.sv
module cfg_mf_detect
    import cfgpd_pkg::*;
#(
    parameter int NSLOT = 32,
    parameter int NFUNC = 8
) (
    input  logic [NSLOT*NFUNC-1:0] present,
    input  logic [SLOT_W-1:0]      slot,
    output logic                   mfdev
);

    logic [NSLOT-1:0] slot_multi;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign slot_multi[s] = ($countones(present[s*NFUNC +: NFUNC]) > 1);
    end

    always_comb begin
        mfdev = 1'b0;
        if (int'(slot) < NSLOT) begin
            mfdev = slot_multi[slot];
        end
    end

endmodule

// File: rtl/cfg_read_return.sv
module cfg_read_return
    import cfgpd_pkg::*;
(
    input  stage_t      st,
    input  logic [31:0] cfg_rdata,
    input  logic        mfdev,
    output logic [31:0] rdata
);

    logic [31:0] raw;

    always_comb begin
        case (st.kind)
            AK_CFG: begin
                raw = cfg_rdata;
                if (st.dw == HDR_DW && st.be[HDR_LANE]) begin
                    raw[MF_BIT] = mfdev;
                end
                raw = raw >> {st.lane, 3'b000};
            end
            AK_LATCH: raw = st.data;
            default:  raw = 32'hFFFF_FFFF;
        endcase
        rdata = raw & size_mask(st.size);
    end

endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
    import cfgpd_pkg::*;
#(
    parameter int NSLOT = 32,
    parameter int NFUNC = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   io_valid,
    input  logic                   io_write,
    input  logic [15:0]            io_port,
    input  logic [2:0]             io_size,
    input  logic [31:0]            io_wdata,
    output logic                   io_hit,
    output logic                   io_rvalid,
    output logic [31:0]            io_rdata,
    input  logic [NSLOT*NFUNC-1:0] present,
    output logic                   cfg_req,
    output logic                   cfg_we,
    output logic [SLOT_W-1:0]      cfg_slot,
    output logic [FUNC_W-1:0]      cfg_func,
    output logic [DW_W-1:0]        cfg_dword,
    output logic [3:0]             cfg_be,
    output logic [31:0]            cfg_wdata,
    input  logic [31:0]            cfg_rdata
);

    logic [31:0]       latch_q;
    logic [OFF_W-1:0]  lat_off;
    logic [FUNC_W-1:0] lat_func;
    logic [SLOT_W-1:0] lat_slot;
    logic              latch_wr;
    stage_t            nxt;
    stage_t            s1;
    logic              mfdev;
    logic [31:0]       ret_data;

    cfg_addr_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (latch_wr),
        .wr_data (io_wdata),
        .latch_q (latch_q),
        .off     (lat_off),
        .func    (lat_func),
        .slot    (lat_slot)
    );

    cfg_access_decode #(.NSLOT(NSLOT), .NFUNC(NFUNC)) u_dec (
        .io_valid (io_valid),
        .io_write (io_write),
        .io_port  (io_port),
        .io_size  (io_size),
        .io_wdata (io_wdata),
        .latch_q  (latch_q),
        .lat_off  (lat_off),
        .lat_func (lat_func),
        .lat_slot (lat_slot),
        .present  (present),
        .io_hit   (io_hit),
        .latch_wr (latch_wr),
        .nxt      (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1 <= nxt;
        end
    end

    assign cfg_req   = (s1.kind == AK_CFG);
    assign cfg_we    = cfg_req && s1.we;
    assign cfg_slot  = s1.slot;
    assign cfg_func  = s1.func;
    assign cfg_dword = s1.dw;
    assign cfg_be    = cfg_req ? s1.be : 4'b0000;
    assign cfg_wdata = s1.data;

    cfg_mf_detect #(.NSLOT(NSLOT), .NFUNC(NFUNC)) u_mf (
        .present (present),
        .slot    (s1.slot),
        .mfdev   (mfdev)
    );

    cfg_read_return u_ret (
        .st        (s1),
        .cfg_rdata (cfg_rdata),
        .mfdev     (mfdev),
        .rdata     (ret_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            io_rvalid <= 1'b0;
            io_rdata  <= '0;
        end else begin
            io_rvalid <= (s1.kind != AK_IDLE) && !s1.we;
            io_rdata  <= ret_data;
        end
    end

    // R1: nothing is pending right after reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!io_rvalid && !cfg_req));

    // R3: a request only follows a data-window access one cycle earlier
    assert_req_from_window_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> $past(io_valid && io_port[15:2] == PORT_DATA[15:2]));

    // R3: byte enables cover one, two or four lanes
    assert_be_width_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> ($countones(cfg_be) == 1 || $countones(cfg_be) == 2 ||
                     $countones(cfg_be) == 4));

    // R4: an illegal size never reaches the register array
    assert_bad_size_dropped_R4: assert property (@(posedge clk) disable iff (rst)
        (io_valid && !size_legal(io_size)) |=> !cfg_req);

    // R9: interrupt-routing ports never produce a request
    assert_irq_no_req_R9: assert property (@(posedge clk) disable iff (rst)
        (io_valid && (io_port == PORT_IRQ0 || io_port == PORT_IRQ1)) |=> !cfg_req);

    // R10: every read is answered two edges later
    assert_read_answered_R10: assert property (@(posedge clk) disable iff (rst)
        (io_valid && !io_write) |-> ##2 io_rvalid);

    // R7: single-byte responses are zero-extended
    assert_byte_trunc_R7: assert property (@(posedge clk) disable iff (rst)
        (s1.kind != AK_IDLE && !s1.we && s1.size == 3'd1) |=> (io_rdata[31:8] == 24'd0));

endmodule

// File: tb/sim_cfg_port_decoder.sv
module sim_cfg_port_decoder;

    localparam int NSLOT = 32;
    localparam int NFUNC = 8;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   io_valid = 1'b0;
    logic                   io_write = 1'b0;
    logic [15:0]            io_port = '0;
    logic [2:0]             io_size = '0;
    logic [31:0]            io_wdata = '0;
    logic                   io_hit;
    logic                   io_rvalid;
    logic [31:0]            io_rdata;
    logic [NSLOT*NFUNC-1:0] present = '0;
    logic                   cfg_req;
    logic                   cfg_we;
    logic [4:0]             cfg_slot;
    logic [2:0]             cfg_func;
    logic [5:0]             cfg_dword;
    logic [3:0]             cfg_be;
    logic [31:0]            cfg_wdata;
    logic [31:0]            cfg_rdata;

    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    function automatic logic [31:0] model(input logic [4:0] s, input logic [2:0] f,
                                          input logic [5:0] dw);
        return {2'b10, dw, f, s, 8'h3C, s[2:0], f, 2'b11};
    endfunction

    assign cfg_rdata = model(cfg_slot, cfg_func, cfg_dword);

    cfg_port_decoder #(.NSLOT(NSLOT), .NFUNC(NFUNC)) u0 (
        .clk(clk), .rst(rst), .io_valid(io_valid), .io_write(io_write),
        .io_port(io_port), .io_size(io_size), .io_wdata(io_wdata),
        .io_hit(io_hit), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
        .present(present), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_slot(cfg_slot), .cfg_func(cfg_func), .cfg_dword(cfg_dword),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    logic        g_hit, g_req, g_we, g_rvalid;
    logic [5:0]  g_dw;
    logic [3:0]  g_be;
    logic [31:0] g_wdata, g_rdata;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [15:0] port, input logic [2:0] size,
                          input logic [31:0] wd);
        @(negedge clk);
        io_valid = 1'b1; io_write = we; io_port = port; io_size = size; io_wdata = wd;
        #1 g_hit = io_hit;
        @(posedge clk);
        @(negedge clk);
        io_valid = 1'b0;
        g_req = cfg_req; g_we = cfg_we; g_dw = cfg_dword; g_be = cfg_be; g_wdata = cfg_wdata;
        @(posedge clk);
        @(negedge clk);
        g_rvalid = io_rvalid; g_rdata = io_rdata;
    endtask

    task automatic set_addr(input logic [4:0] s, input logic [2:0] f, input logic [7:0] off);
        access(1'b1, 16'h0CF8, 3'd4, {8'h00, 8'h00, s, f, off});
    endtask

    task automatic read_expect(input string tag, input logic [15:0] port,
                               input logic [2:0] size, input logic [31:0] exp);
        access(1'b0, port, size, 32'h0);
        check({tag, " rvalid"}, {31'd0, g_rvalid}, 32'd1);
        check({tag, " rdata"}, g_rdata, exp);
    endtask

    task automatic t_reset;
        check("R1 rvalid after reset", {31'd0, io_rvalid}, 32'd0);
        check("R1 cfg_req after reset", {31'd0, cfg_req}, 32'd0);
        read_expect("R1 latch cleared", 16'h0CF8, 3'd4, 32'h0);
    endtask

    task automatic t_latch;
        access(1'b1, 16'h0CF8, 3'd4, 32'hAB12_3456);
        check("R2 latch write hit", {31'd0, g_hit}, 32'd1);
        check("R10 write no rvalid", {31'd0, g_rvalid}, 32'd0);
        read_expect("R2 latch readback", 16'h0CF8, 3'd4, 32'h0012_3456);
        access(1'b1, 16'h0CF8, 3'd2, 32'h0000_FFFF);
        read_expect("R2 narrow write ignored", 16'h0CF8, 3'd4, 32'h0012_3456);
        read_expect("R2 narrow latch read", 16'h0CF8, 3'd1, 32'h0000_00FF);
    endtask

    task automatic t_reads;
        set_addr(5'd0, 3'd0, 8'h08);
        read_expect("R7 dword read", 16'h0CFC, 3'd4, model(5'd0, 3'd0, 6'd2));
        check("R3 dword index", {26'd0, g_dw}, 32'd2);
        check("R3 dword be", {28'd0, g_be}, 32'hF);
        read_expect("R7 byte lane1", 16'h0CFD, 3'd1, 32'h0000_003C);
        check("R3 lane1 be", {28'd0, g_be}, 32'h2);
        read_expect("R7 half lane2", 16'h0CFE, 3'd2, {16'h0, model(5'd0, 3'd0, 6'd2) >> 16});
        check("R3 lane2 be", {28'd0, g_be}, 32'hC);
    endtask

    task automatic t_writes;
        set_addr(5'd0, 3'd0, 8'h10);
        access(1'b1, 16'h0CFE, 3'd2, 32'h0000_1234);
        check("R3 write req", {30'd0, g_req, g_we}, 32'd3);
        check("R3 write dword", {26'd0, g_dw}, 32'd4);
        check("R3 write be", {28'd0, g_be}, 32'hC);
        check("R3 write data", g_wdata, 32'h1234_0000);
        check("R10 cfg write no rvalid", {31'd0, g_rvalid}, 32'd0);
        access(1'b1, 16'h0CFF, 3'd1, 32'h0000_00AB);
        check("R3 byte write be", {28'd0, g_be}, 32'h8);
        check("R3 byte write data", g_wdata, 32'hAB00_0000);
    endtask

    task automatic t_size;
        set_addr(5'd0, 3'd0, 8'h00);
        read_expect("R4 size3 read", 16'h0CFC, 3'd3, 32'hFFFF_FFFF);
        check("R4 size3 read no req", {31'd0, g_req}, 32'd0);
        access(1'b1, 16'h0CFC, 3'd0, 32'h1);
        check("R4 size0 write no req", {31'd0, g_req}, 32'd0);
    endtask

    task automatic t_align;
        set_addr(5'd0, 3'd0, 8'h01);
        read_expect("R5 unaligned half", 16'h0CFC, 3'd2, 32'h0000_FFFF);
        check("R5 unaligned no req", {31'd0, g_req}, 32'd0);
        read_expect("R3 lane makes aligned", 16'h0CFD, 3'd2, {16'h0, model(5'd0, 3'd0, 6'd0) >> 16});
        check("R3 lane aligned be", {28'd0, g_be}, 32'hC);
        set_addr(5'd0, 3'd0, 8'h02);
        access(1'b1, 16'h0CFC, 3'd4, 32'h5555_5555);
        check("R5 unaligned write no req", {31'd0, g_req}, 32'd0);
    endtask

    task automatic t_absent;
        set_addr(5'd1, 3'd0, 8'h00);
        read_expect("R6 absent dword", 16'h0CFC, 3'd4, 32'hFFFF_FFFF);
        check("R6 absent no req", {31'd0, g_req}, 32'd0);
        access(1'b1, 16'h0CFC, 3'd4, 32'h1);
        check("R6 absent write no req", {31'd0, g_req}, 32'd0);
        set_addr(5'd0, 3'd1, 8'h00);
        read_expect("R6 absent func byte", 16'h0CFC, 3'd1, 32'h0000_00FF);
    endtask

    task automatic t_mf;
        set_addr(5'd3, 3'd0, 8'h0C);
        read_expect("R8 multi slot sets", 16'h0CFC, 3'd4, model(5'd3, 3'd0, 6'd3) | 32'h0080_0000);
        set_addr(5'd3, 3'd2, 8'h0C);
        read_expect("R8 multi byte lane2", 16'h0CFE, 3'd1, 32'h0000_00C3);
        read_expect("R8 byte3 untouched", 16'h0CFF, 3'd1, 32'h0000_0083);
        set_addr(5'd5, 3'd4, 8'h0E);
        read_expect("R8 single slot clears", 16'h0CFC, 3'd1, 32'h0000_0005);
        present[5*NFUNC + 0] = 1'b1;
        read_expect("R8 live occupancy", 16'h0CFC, 3'd1, 32'h0000_0085);
        present[5*NFUNC + 0] = 1'b0;
    endtask

    task automatic t_irq;
        set_addr(5'd0, 3'd0, 8'h24);
        access(1'b1, 16'h0C00, 3'd1, 32'hFF);
        check("R9 irq0 hit", {31'd0, g_hit}, 32'd1);
        check("R9 irq0 no req", {31'd0, g_req}, 32'd0);
        access(1'b1, 16'h0C01, 3'd1, 32'hFF);
        check("R9 irq1 hit", {31'd0, g_hit}, 32'd1);
        read_expect("R9 latch untouched", 16'h0CF8, 3'd4, 32'h0000_0024);
        read_expect("R9 irq read ones", 16'h0C00, 3'd1, 32'h0000_00FF);
        access(1'b1, 16'h0CF9, 3'd1, 32'h0);
        check("R9 unclaimed no hit", {31'd0, g_hit}, 32'd0);
    endtask

    initial begin
        #2_000_000;
        nerr++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        present[0*NFUNC + 0] = 1'b1;
        present[3*NFUNC + 0] = 1'b1;
        present[3*NFUNC + 2] = 1'b1;
        present[5*NFUNC + 4] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latch();
        t_reads();
        t_writes();
        t_size();
        t_align();
        t_absent();
        t_mf();
        t_irq();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule